// File: doc/BRIEF.md
# PLL Divider Retune Sequencer

This block is the control machine that moves an integer-divider PLL from one setting to another without exposing downstream logic to an unlocked clock. A one-cycle start pulse hands it a new input-divider, output-divider, feedback-divider and bandwidth-divider value. On that edge it captures the divider fields currently held in the PLL configuration register, and it captures whether the clock output selector is running from the PLL. If it is, the sequencer first moves the selector to the slow reference. It then holds the PLL in reset, writes the new fields, releases reset, waits a settle time that grows with the input divider, and polls the lock indication within a bounded budget.

When lock is seen, the sequence ends. When the budget runs out, the sequencer raises its error flag and replays the same reset, write and settle steps with the captured old fields. A failure during that restore pass does not start another restore. In every case the selector is put back to normal mode at the end if it was moved at the start. The analog core is outside the block and is represented by the lock input. Choosing divider values for a target frequency is also left to other logic.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset, busy, done, err and all three write strobes (mode_we, rst_we, cfg_we) are 0.
- R2: When start is accepted while mode_in is 1 (normal), the first cycle of the sequence is a mode write with mode_wdata 0 (slow).
- R3: When start is accepted while mode_in is 0 (slow) or 2 (deep), no mode write occurs at any point in that sequence.
- R4: Each pass is one cycle of rst_we with rst_wdata 1, then one cycle of cfg_we, then one cycle of rst_we with rst_wdata 0. The new fields are written as the requested value minus one.
- R5: After reset is released, the sequencer waits (N+1)*500/24+1 microsecond units of TICK_CYCLES clocks each, where N is the written input-divider field. lock_in is ignored during this wait.
- R6: From the cycle after the wait, lock_in is sampled on each clock for up to LOCK_BUDGET cycles. Lock on any sampled cycle, the last one included, ends the sequence on the next cycle.
- R7: If the budget runs out on the first pass, err rises and a second pass writes the raw divider fields captured from cur_* on the start edge. Later changes to cur_* do not affect these values.
- R8: If the restore pass also runs out of budget, the sequence ends with err at 1 and no third pass follows.
- R9: The final cycle writes mode_wdata 1 (normal) if and only if the sequence moved the selector to slow, whether or not a rollback took place.
- R10: done is a single-cycle pulse on the final cycle. err holds its value while idle and is cleared on the next accepted start.
- R11: A start pulse while busy is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request pulse |
| mode_in | input | MODE_W | Current output selector (0 slow, 1 normal, 2 deep) |
| new_nr | input | NR_W+1 | Requested input divider value |
| new_no | input | NO_W+1 | Requested output divider value |
| new_nf | input | NF_W+1 | Requested feedback divider value |
| new_nb | input | NB_W+1 | Requested bandwidth divider value |
| cur_nr | input | NR_W | Raw input divider field now in the register |
| cur_no | input | NO_W | Raw output divider field now in the register |
| cur_nf | input | NF_W | Raw feedback divider field now in the register |
| cur_nb | input | NB_W | Raw bandwidth divider field now in the register |
| lock_in | input | 1 | PLL lock indication |
| mode_we | output | 1 | Selector write strobe |
| mode_wdata | output | MODE_W | Selector write value |
| rst_we | output | 1 | PLL reset bit write strobe |
| rst_wdata | output | 1 | PLL reset bit value |
| cfg_we | output | 1 | Divider field write strobe |
| cfg_nr | output | NR_W | Input divider field to write |
| cfg_no | output | NO_W | Output divider field to write |
| cfg_nf | output | NF_W | Feedback divider field to write |
| cfg_nb | output | NB_W | Bandwidth divider field to write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | End-of-sequence pulse |
| err | output | 1 | Lock timeout seen in the last sequence |

## Verification
On every cycle, the assertions check that parking follows an accepted start from normal mode, that a divider write always sits between an asserted and a released PLL reset, that done lasts one cycle and drops busy, that err holds while idle, and that lock cannot end the settle wait. Other properties need whole sequences and come only from the bench scenarios: the exact settle length for small and maximum input dividers, lock on the last budget cycle, rollback to the captured fields after cur_* has been changed, the single restore attempt, and a mode restore only after parking.

// File: rtl/pll_retune_seq.sv
module pll_retune_seq #(
  parameter int MODE_W      = 2,
  parameter int NR_W        = 6,
  parameter int NO_W        = 4,
  parameter int NF_W        = 13,
  parameter int NB_W        = 12,
  parameter int LOCK_BUDGET = 24000000,
  parameter int TICK_CYCLES = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode_in,
  input  logic [NR_W:0]     new_nr,
  input  logic [NO_W:0]     new_no,
  input  logic [NF_W:0]     new_nf,
  input  logic [NB_W:0]     new_nb,
  input  logic [NR_W-1:0]   cur_nr,
  input  logic [NO_W-1:0]   cur_no,
  input  logic [NF_W-1:0]   cur_nf,
  input  logic [NB_W-1:0]   cur_nb,
  input  logic              lock_in,
  output logic              mode_we,
  output logic [MODE_W-1:0] mode_wdata,
  output logic              rst_we,
  output logic              rst_wdata,
  output logic              cfg_we,
  output logic [NR_W-1:0]   cfg_nr,
  output logic [NO_W-1:0]   cfg_no,
  output logic [NF_W-1:0]   cfg_nf,
  output logic [NB_W-1:0]   cfg_nb,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int PW      = $clog2(LOCK_BUDGET + 1);
  localparam int DLY_MAX = ((1 << NR_W) * 500) / 24 + 1;
  localparam int UW      = $clog2(DLY_MAX + 1);
  localparam int SW      = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [MODE_W-1:0] M_SLOW = MODE_W'(0);
  localparam logic [MODE_W-1:0] M_NORM = MODE_W'(1);

  typedef enum logic [2:0] {
    S_IDLE, S_PARK, S_RST_ON, S_WRITE, S_RST_OFF, S_SETTLE, S_POLL, S_FINISH
  } state_t;

  state_t          state;
  logic            remux, rollback;
  logic [NR_W-1:0] sav_nr;
  logic [NO_W-1:0] sav_no;
  logic [NF_W-1:0] sav_nf;
  logic [NB_W-1:0] sav_nb;
  logic [UW-1:0]   us_cnt;
  logic [SW-1:0]   sub_cnt;
  logic [PW-1:0]   poll_cnt;
  logic [31:0]     dly_full;
  logic [NR_W:0]   nr_m1;
  logic [NO_W:0]   no_m1;
  logic [NF_W:0]   nf_m1;
  logic [NB_W:0]   nb_m1;

  assign nr_m1    = new_nr - 1'b1;
  assign no_m1    = new_no - 1'b1;
  assign nf_m1    = new_nf - 1'b1;
  assign nb_m1    = new_nb - 1'b1;
  assign dly_full = ((32'(cfg_nr) + 32'd1) * 32'd500) / 32'd24 + 32'd1;

  assign busy       = (state != S_IDLE);
  assign done       = (state == S_FINISH);
  assign mode_we    = (state == S_PARK) || ((state == S_FINISH) && remux);
  assign mode_wdata = (state == S_PARK) ? M_SLOW : M_NORM;
  assign rst_we     = (state == S_RST_ON) || (state == S_RST_OFF);
  assign rst_wdata  = (state == S_RST_ON);
  assign cfg_we     = (state == S_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      remux    <= 1'b0;
      rollback <= 1'b0;
      err      <= 1'b0;
      sav_nr   <= '0;
      sav_no   <= '0;
      sav_nf   <= '0;
      sav_nb   <= '0;
      cfg_nr   <= '0;
      cfg_no   <= '0;
      cfg_nf   <= '0;
      cfg_nb   <= '0;
      us_cnt   <= '0;
      sub_cnt  <= '0;
      poll_cnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          sav_nr   <= cur_nr;
          sav_no   <= cur_no;
          sav_nf   <= cur_nf;
          sav_nb   <= cur_nb;
          cfg_nr   <= nr_m1[NR_W-1:0];
          cfg_no   <= no_m1[NO_W-1:0];
          cfg_nf   <= nf_m1[NF_W-1:0];
          cfg_nb   <= nb_m1[NB_W-1:0];
          err      <= 1'b0;
          rollback <= 1'b0;
          remux    <= (mode_in == M_NORM);
          state    <= (mode_in == M_NORM) ? S_PARK : S_RST_ON;
        end
        S_PARK:   state <= S_RST_ON;
        S_RST_ON: state <= S_WRITE;
        S_WRITE:  state <= S_RST_OFF;
        S_RST_OFF: begin
          us_cnt  <= dly_full[UW-1:0];
          sub_cnt <= '0;
          state   <= S_SETTLE;
        end
        S_SETTLE: begin
          if (sub_cnt == SW'(TICK_CYCLES - 1)) begin
            sub_cnt <= '0;
            if (us_cnt == UW'(1)) begin
              poll_cnt <= '0;
              state    <= S_POLL;
            end else begin
              us_cnt <= us_cnt - 1'b1;
            end
          end else begin
            sub_cnt <= sub_cnt + 1'b1;
          end
        end
        S_POLL: begin
          if (lock_in) begin
            state <= S_FINISH;
          end else if (poll_cnt == PW'(LOCK_BUDGET - 1)) begin
            err <= 1'b1;
            if (!rollback) begin
              rollback <= 1'b1;
              cfg_nr   <= sav_nr;
              cfg_no   <= sav_no;
              cfg_nf   <= sav_nf;
              cfg_nb   <= sav_nb;
              state    <= S_RST_ON;
            end else begin
              state <= S_FINISH;
            end
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_park_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && mode_in == M_NORM) |=> (mode_we && mode_wdata == M_SLOW));

  p_write_in_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (rst_we && !rst_wdata));

  p_write_after_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_we && rst_wdata) |=> cfg_we);

  p_settle_no_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SETTLE) |=> !done);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(err));

  p_ignore_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);

endmodule

// File: tb/pll_retune_seq_bench.sv
`timescale 1ns/1ps
module pll_retune_seq_bench;
  localparam int MODE_W = 2, NR_W = 6, NO_W = 4, NF_W = 13, NB_W = 12;
  localparam int BUDGET = 20, TICK = 2;

  logic clk = 0, rst_n = 0, start = 0, lock_in = 0;
  logic [MODE_W-1:0] mode_in = '0;
  logic [NR_W:0] new_nr = '0; logic [NO_W:0] new_no = '0;
  logic [NF_W:0] new_nf = '0; logic [NB_W:0] new_nb = '0;
  logic [NR_W-1:0] cur_nr = '0; logic [NO_W-1:0] cur_no = '0;
  logic [NF_W-1:0] cur_nf = '0; logic [NB_W-1:0] cur_nb = '0;
  logic mode_we, rst_we, rst_wdata, cfg_we, busy, done, err;
  logic [MODE_W-1:0] mode_wdata;
  logic [NR_W-1:0] cfg_nr; logic [NO_W-1:0] cfg_no;
  logic [NF_W-1:0] cfg_nf; logic [NB_W-1:0] cfg_nb;

  pll_retune_seq #(.MODE_W(MODE_W), .NR_W(NR_W), .NO_W(NO_W), .NF_W(NF_W), .NB_W(NB_W),
                   .LOCK_BUDGET(BUDGET), .TICK_CYCLES(TICK)) u_pll_retune_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode_in),
    .new_nr(new_nr), .new_no(new_no), .new_nf(new_nf), .new_nb(new_nb),
    .cur_nr(cur_nr), .cur_no(cur_no), .cur_nf(cur_nf), .cur_nb(cur_nb),
    .lock_in(lock_in), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .rst_we(rst_we), .rst_wdata(rst_wdata), .cfg_we(cfg_we),
    .cfg_nr(cfg_nr), .cfg_no(cfg_no), .cfg_nf(cfg_nf), .cfg_nb(cfg_nb),
    .busy(busy), .done(done), .err(err));

  always #2 clk = ~clk;

  typedef struct {
    bit mwe; int mwd; bit rwe; bit rwd; bit cwe;
    int nr; int no; int nf; int nb;
    bit lk; bit dn; bit er; bit bz;
  } rec_t;

  rec_t sched[$];
  int checks = 0, failures = 0, cyc = 0;
  bit cur_err = 0, exp_err = 0, noisy = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic rec_t blank();
    rec_t r;
    r = '{default: 0};
    r.bz = 1; r.er = cur_err;
    return r;
  endfunction

  task automatic add_pass(int nr, int no, int nf, int nb, int lk_at, output bit ok);
    rec_t r;
    int dly;
    r = blank(); r.rwe = 1; r.rwd = 1; sched.push_back(r);
    r = blank(); r.cwe = 1; r.nr = nr; r.no = no; r.nf = nf; r.nb = nb; sched.push_back(r);
    r = blank(); r.rwe = 1; r.rwd = 0; sched.push_back(r);
    dly = ((nr + 1) * 500) / 24 + 1;
    for (int i = 0; i < dly * TICK; i++) begin
      r = blank(); r.lk = noisy; sched.push_back(r);
    end
    ok = 0;
    for (int i = 0; i < BUDGET; i++) begin
      r = blank(); r.lk = (i == lk_at); sched.push_back(r);
      if (i == lk_at) begin ok = 1; break; end
    end
  endtask

  task automatic build(int mode, int nnr, int nno, int nnf, int nnb,
                       int onr, int ono, int onf, int onb, int lk1, int lk2);
    rec_t r;
    bit remux, ok;
    sched.delete();
    cur_err = 0;
    remux = (mode == 1);
    if (remux) begin r = blank(); r.mwe = 1; r.mwd = 0; sched.push_back(r); end
    add_pass(nnr - 1, nno - 1, nnf - 1, nnb - 1, lk1, ok);
    if (!ok) begin
      cur_err = 1;
      add_pass(onr, ono, onf, onb, lk2, ok);
    end
    r = blank(); r.dn = 1; r.mwe = remux; r.mwd = 1; sched.push_back(r);
    exp_err = cur_err;
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic compare(rec_t r);
    checks++;
    chk("R2,R3,R9", "mode_we", mode_we, r.mwe);
    if (r.mwe) chk("R2,R9", "mode_wdata", mode_wdata, r.mwd);
    chk("R4", "rst_we", rst_we, r.rwe);
    if (r.rwe) chk("R4", "rst_wdata", rst_wdata, r.rwd);
    chk("R4,R5", "cfg_we", cfg_we, r.cwe);
    if (r.cwe) begin
      chk("R4,R7", "cfg_nr", cfg_nr, r.nr);
      chk("R4,R7", "cfg_no", cfg_no, r.no);
      chk("R4,R7", "cfg_nf", cfg_nf, r.nf);
      chk("R4,R7", "cfg_nb", cfg_nb, r.nb);
    end
    chk("R6,R10", "done", done, r.dn);
    chk("R7,R8,R10", "err", err, r.er);
    chk("R1,R6,R11", "busy", busy, r.bz);
  endtask

  task automatic idle_check(int n);
    rec_t r;
    r = '{default: 0}; r.er = exp_err;
    for (int i = 0; i < n; i++) begin
      compare(r);
      @(negedge clk);
    end
  endtask

  task automatic run(int mode, int nnr, int nno, int nnf, int nnb,
                     int onr, int ono, int onf, int onb, int lk1, int lk2, int poke);
    mode_in = MODE_W'(mode);
    new_nr = (NR_W+1)'(nnr); new_no = (NO_W+1)'(nno);
    new_nf = (NF_W+1)'(nnf); new_nb = (NB_W+1)'(nnb);
    cur_nr = NR_W'(onr); cur_no = NO_W'(ono); cur_nf = NF_W'(onf); cur_nb = NB_W'(onb);
    start = 1;
    build(mode, nnr, nno, nnf, nnb, onr, ono, onf, onb, lk1, lk2);
    @(negedge clk);
    start = 0;
    for (int k = 0; k < sched.size(); k++) begin
      compare(sched[k]);
      lock_in = sched[k].lk;
      if (k == poke) begin
        // R11 and R7: busy start ignored, cur_* changes after the start edge have no effect
        start = 1; mode_in = MODE_W'(1);
        new_nr = '1; cur_nr = ~cur_nr; cur_no = ~cur_no; cur_nf = ~cur_nf; cur_nb = ~cur_nb;
      end else if (k == poke + 1) begin
        start = 0;
      end
      @(negedge clk);
    end
    lock_in = 0; start = 0;
    idle_check(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle_check(3);                                                  // R1
    run(1, 3, 2, 50, 25, 1, 1, 30, 15, 3, -1, -1);                  // R2 R4 R5 R6 R9 R10
    run(0, 1, 1, 8, 4, 0, 0, 7, 3, 0, -1, -1);                      // R3
    noisy = 1;                                                      // R5 lock ignored while settling
    run(2, 5, 4, 100, 60, 9, 2, 200, 99, -1, 5, 4);                 // R3 R7 R11
    noisy = 0;
    run(1, 2, 2, 20, 10, 4, 3, 40, 20, -1, -1, -1);                 // R8 R9
    idle_check(5);                                                  // R10 err held
    run(1, 64, 16, 8192, 4096, 0, 0, 0, 0, BUDGET - 1, -1, -1);     // R5 max divider, R6 last poll, R10 err cleared
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule